// File: doc/BRIEF.md
# Interleaved Multi-Lane Phase Generator

This block feeds a time-interleaved frequency synthesizer. Each clock it hands out a group of phase words, one per lane, so that a bank of parallel amplitude evaluators can turn them into consecutive output samples in a single cycle. This raises the effective sample rate by the lane count. A single shared accumulator advances by the lane count times the tuning word on every enabled cycle. Each lane adds a fixed multiple of the tuning word to the accumulator value to form its own phase.

The lane count is a power-of-two parameter. Multiplying the tuning word by it is therefore a left shift, and each lane's offset is a constant sum of shifted copies of the tuning word, so no general multiplier is built. All phase arithmetic wraps modulo 2^PHASE_W. The lane phases are registered and appear together one cycle after the enable is sampled. The lowest lane on the bus carries the earliest sample.

Top module: `ilv_phase_gen`

## Requirements
- R1: While rstN is low, and on the first cycle after it is released, every lane of lanePhase is 0 and valid is 0. The accumulator starts from 0.
- R2: Every cycle in which en is sampled high, the accumulator advances by LANES·fcw modulo 2^PHASE_W. The top lane (index LANES-1) of the resulting output equals the new accumulator value.
- R3: Lane k (bus bits [k·PHASE_W +: PHASE_W], k = 0..LANES-1) presents A + (k+1)·fcw modulo 2^PHASE_W. Here A is the accumulator value and fcw is the tuning word, both sampled at the enabling edge.
- R4: valid is 1 in exactly those cycles that follow an edge at which en was sampled high. All lanes update on that same edge.
- R5: An edge at which en is low changes neither the accumulator nor any lane, whatever fcw is at that time.
- R6: A new fcw applies to every lane of the same output group. The first lane of the group continues from the previous group's top lane by exactly one new fcw.
- R7: Across consecutive enabled cycles, the lanes read in order from lane 0 to lane LANES-1, group after group, match the sequence of a single accumulator that starts at 0 and adds fcw once per sample.
- R8: Sums that exceed 2^PHASE_W-1 wrap with the carry discarded. This holds for the accumulator step and for every lane offset, including fcw = 2^PHASE_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the phase and load a new lane group |
| fcw | input | PHASE_W | Frequency tuning word, phase increment per sample |
| lanePhase | output | LANES·PHASE_W | Lane phases, lane 0 in the low bits, earliest sample first |
| valid | output | 1 | Lane group was loaded on the last edge |

## Verification
The bench sweeps every 12-bit tuning word once with 16 lanes, so every offset multiple meets every carry pattern, the all-ones word included. A wrong shift or a dropped carry in one lane's offset shows up there as a single bad lane. The bench then interleaves disabled cycles while it changes fcw. A design that let the hold leak would move the lanes or skip ahead in the accumulator. The test also catches a design that registered the offsets one cycle late, because it would mix the old and new words inside one group and break the group-to-group continuity that the bench tracks from the outputs alone.

// File: rtl/ilv_phase_pkg.sv
package ilv_phase_pkg;
  typedef struct packed {
    logic stepAcc;
    logic loadLanes;
  } phase_strobe_t;
endpackage

// File: rtl/ilv_phase_ctrl.sv
module ilv_phase_ctrl
  import ilv_phase_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  output phase_strobe_t strobes,
  output logic          valid
);
  always_comb begin
    strobes.stepAcc   = en;
    strobes.loadLanes = en;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) valid <= 1'b0;
    else       valid <= en;
  end

  // R4: valid marks exactly the cycles after an enabled edge
  a_r4_valid_after_en: assert property (@(posedge clk) disable iff (!rstN)
    en |=> valid);
  a_r4_idle_after_off: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !valid);
endmodule

// File: rtl/ilv_phase_dp.sv
module ilv_phase_dp
  import ilv_phase_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int LANES   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PHASE_W-1:0]       fcw,
  input  phase_strobe_t            strobes,
  input  logic                     valid,
  output logic [LANES*PHASE_W-1:0] lanePhase
);
  localparam int SHIFT = $clog2(LANES);

  // constant multiple of v built from shifted copies, one per set bit of k
  function automatic logic [PHASE_W-1:0] mulConst(input logic [PHASE_W-1:0] v, input int k);
    logic [PHASE_W-1:0] sum;
    sum = '0;
    for (int b = 0; b <= SHIFT; b++)
      if (k[b]) sum = sum + (v << b);
    return sum;
  endfunction

  logic [PHASE_W-1:0] accQ;
  logic [PHASE_W-1:0] accStep;
  logic [PHASE_W-1:0] laneQ [LANES];

  assign accStep = fcw << SHIFT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                accQ <= '0;
    else if (strobes.stepAcc) accQ <= accQ + accStep;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0] offs;
    always_comb offs = mulConst(fcw, k + 1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  laneQ[k] <= '0;
      else if (strobes.loadLanes) laneQ[k] <= accQ + offs;
    end

    assign lanePhase[k*PHASE_W +: PHASE_W] = laneQ[k];
  end

  // R2: top lane lands on the freshly stepped accumulator
  a_r2_top_lane_acc: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> laneQ[LANES-1] == accQ);

  // R5: a disabled edge leaves accumulator and lanes alone
  a_r5_hold_acc: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stepAcc |=> $stable(accQ));
  a_r5_hold_lane: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLanes |=> ($stable(laneQ[0]) && $stable(laneQ[LANES-1])));

  // R6: back-to-back groups join with one fcw step
  a_r6_group_join: assert property (@(posedge clk) disable iff (!rstN)
    (valid && $past(valid)) |-> laneQ[0] == $past(laneQ[LANES-1]) + $past(fcw));
endmodule

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen
  import ilv_phase_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int LANES   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       fcw,
  output logic [LANES*PHASE_W-1:0] lanePhase,
  output logic                     valid
);
  initial begin
    if ((LANES & (LANES - 1)) != 0 || LANES < 1)
      $error("LANES must be a power of two");
  end

  phase_strobe_t strobes;

  ilv_phase_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .strobes (strobes),
    .valid   (valid)
  );

  ilv_phase_dp #(.PHASE_W(PHASE_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fcw       (fcw),
    .strobes   (strobes),
    .valid     (valid),
    .lanePhase (lanePhase)
  );
endmodule

// File: tb/ilv_phase_gen_tb.sv
module ilv_phase_gen_tb;
  localparam int N = 12;
  localparam int M = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           en = 1'b0;
  logic [N-1:0]   fcw = '0;
  logic [M*N-1:0] lanePhase;
  logic           valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [N-1:0] refPhase;
  logic [N-1:0] expLane [M];
  logic         expValid;
  logic [N-1:0] seenLast;
  bit           haveLast;

  always #2.5 clk = ~clk;

  ilv_phase_gen #(.PHASE_W(N), .LANES(M)) u_dut (
    .clk(clk), .rstN(rstN), .en(en), .fcw(fcw),
    .lanePhase(lanePhase), .valid(valid)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // apply one cycle of stimulus at a falling edge, then check after the rising edge
  task automatic step(input logic e, input logic [N-1:0] f, input string req);
    logic [N-1:0] grpFirst;
    en  = e;
    fcw = f;
    if (e) begin
      for (int k = 0; k < M; k++) expLane[k] = refPhase + N'((k + 1)) * f;
      refPhase = refPhase + N'(M) * f;
    end
    expValid = e;
    @(posedge clk);
    @(negedge clk);
    check({req, " R4 valid"}, {11'b0, valid}, {11'b0, expValid});
    for (int k = 0; k < M; k++)
      check({req, " lane"}, lanePhase[k*N +: N], expLane[k]);
    if (e) begin
      grpFirst = lanePhase[N-1:0];
      // R7: continuity observed purely at the ports
      if (haveLast) check("R7 continuity", grpFirst, seenLast + f);
      // R2: top lane equals the single-accumulator value after M steps
      check("R2 top lane", lanePhase[(M-1)*N +: N], refPhase);
      seenLast = lanePhase[(M-1)*N +: N];
      haveLast = 1;
    end
  endtask

  initial begin
    refPhase = '0;
    haveLast = 0;
    for (int k = 0; k < M; k++) expLane[k] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check("R1 valid in reset", {11'b0, valid}, 12'd0);
    for (int k = 0; k < M; k++) check("R1 lane in reset", lanePhase[k*N +: N], '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {11'b0, valid}, 12'd0);
    check("R1 lane after release", lanePhase[N-1:0], '0);

    // R3/R8: sweep every tuning word, enabled each cycle
    for (int f = 0; f < (1 << N); f++) step(1'b1, N'(f), "R3 R8 sweep");
    // R8: all-ones word repeatedly wraps every lane
    repeat (4) step(1'b1, {N{1'b1}}, "R8 wrap");
    // R5: disabled edges with fcw changing must not move anything
    for (int i = 0; i < 40; i++) begin
      step(1'b0, N'(i * 97 + 5), "R5 hold");
      step(1'b1, N'(i * 131 + 7), "R6 change");
    end
    // R6: fcw changing on every enabled cycle
    for (int i = 0; i < 64; i++) step(1'b1, N'(i * 613 + 11), "R6 per-cycle change");
    step(1'b0, 12'h123, "R5 hold end");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule